// File: doc/BRIEF.md
# Compare Timer Peripheral

A register-mapped up-counter with one compare channel. Software picks one of three clock-enable strobes as the timebase, and a prescaler divides it before each step of the counter. The counter either runs over its full range and wraps, or returns to zero on the step after it meets the channel 1 compare value. Two sticky status flags record a compare hit and a wrap from the all-ones count. A mask register selects which flags drive a single level interrupt, and that interrupt only asserts while the timer is enabled.

The bus is a plain synchronous port. A write is taken on the clock edge when `bus_we` is high. Read data is combinational from `bus_addr`. Word offsets select the registers: 0 control, 1 prescale, 2 status, 3 interrupt mask, 4 to 6 compare values 1 to 3, 7 and 8 capture slots that always read zero, and 9 the live count. A control write with bit 15 set performs a soft reset. The soft reset keeps the clock-select, mode and upper control bits but clears the run bits.

Top module: `cmp_timer`

## Requirements
- R1: The counter steps by one only on an advance, and it only advances while the enable bit (control bit 0) is 1. With the enable bit at 0 and no bus write, the count holds.
- R2: With the mode bit (control bit 9) at 1, an advance taken at the all-ones count gives 0 and sets the wrap flag (status bit 5). An advance taken at the all-ones count sets the wrap flag in either mode.
- R3: With the mode bit at 0, an advance taken while the count equals compare 1 gives 0. Any write to compare 1 (offset 4) made while the mode bit is 0 forces the count to 0.
- R4: An advance taken while the count equals compare 1 sets the compare flag (status bit 0) in both modes, and in free-run the count keeps going. When compare 1 is all ones in free-run, both flags rise on the same advance.
- R5: Control bits 8:6 pick the strobe: 001 the peripheral strobe, 010 the fast strobe, 100 the slow strobe. Every other code gives no advance.
- R6: The prescale register keeps 12 bits. One advance occurs for every prescale+1 selected strobes seen while enabled. A write to the prescale register restarts the division phase.
- R7: Writing 1 to status bit 0 or bit 5 clears that flag, and writing 0 leaves it. When a flag is set and cleared in the same cycle, the set wins.
- R8: The interrupt mask keeps the low 6 bits of a write. `irq` is 1 exactly when enable is 1 and either (compare flag and mask bit 0) or (wrap flag and mask bit 5) is 1.
- R9: A control write that takes enable from 0 to 1 with bit 1 set also restarts the count at 0. With bit 1 clear, counting resumes from the held value.
- R10: A control write with bit 15 set stores the written value with bits 15:10 and 5:0 cleared. It clears prescale, status, mask, count and the prescale phase, and sets compares 1 to 3 to all ones.
- R11: Control bits 15:10 read 0. Offsets 7, 8 and 10 to 15 read 0. Writes to offsets 7, 8 and 9 change nothing. Compares 2 and 3 store and return their value and have no other effect.
- R12: After hardware reset, control, prescale, status, mask and count read 0 and compares 1 to 3 read all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| bus_addr | input | 4 | Word offset of the register accessed |
| bus_we | input | 1 | Write strobe, taken on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tick_per | input | 1 | Peripheral clock-enable strobe (code 001) |
| tick_fast | input | 1 | Fast clock-enable strobe (code 010) |
| tick_slow | input | 1 | Slow clock-enable strobe (code 100) |
| irq | output | 1 | Level interrupt |

## Verification
Some properties are checked on every cycle. These are: the count holds while disabled, no advance occurs without enable, a free-run step adds exactly one, a restart at the compare value returns to zero, a compare hit sets its flag, a soft reset clears the run state, and the interrupt stays low while disabled. Other behaviour only shows in the bench's scenarios, where a behavioural model is compared with the read port and `irq` on every clock. That covers strobe selection across all eight codes, the prescale phase and its restart, the same-cycle set-over-clear race, the enable-mode restart against a plain resume, and the compare value at all ones. It also covers the read-back of reserved bits and of ignored offsets.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;

    localparam int REG_W  = 32;
    localparam int ADDR_W = 4;
    localparam int MASK_W = 6;

    // control field positions
    localparam int CR_EN      = 0;
    localparam int CR_ENMOD   = 1;
    localparam int CR_SEL_LSB = 6;
    localparam int CR_SEL_W   = 3;
    localparam int CR_FRR     = 9;
    localparam int CR_SWR     = 15;

    localparam logic [REG_W-1:0] CR_RSVD_MASK = 32'h0000_FC00;
    localparam logic [REG_W-1:0] CR_RUN_MASK  = 32'h0000_003F;

    // status field positions
    localparam int SR_OF1 = 0;
    localparam int SR_ROV = 5;

    typedef enum logic [ADDR_W-1:0] {
        OFS_CTRL  = 4'd0,
        OFS_PRE   = 4'd1,
        OFS_STAT  = 4'd2,
        OFS_MASK  = 4'd3,
        OFS_CMP1  = 4'd4,
        OFS_CMP2  = 4'd5,
        OFS_CMP3  = 4'd6,
        OFS_CAP1  = 4'd7,
        OFS_CAP2  = 4'd8,
        OFS_COUNT = 4'd9
    } reg_ofs_e;

    typedef enum logic [CR_SEL_W-1:0] {
        SRC_OFF  = 3'b000,
        SRC_PER  = 3'b001,
        SRC_FAST = 3'b010,
        SRC_SLOW = 3'b100
    } src_code_e;

    // control pulses from the register block to the datapath
    typedef struct packed {
        logic       soft_rst;
        logic       cnt_zero;
        logic       pre_clr;
        logic [1:0] flag_clr;   // [1] wrap, [0] compare
    } timer_ctl_t;

    typedef struct packed {
        logic rov;
        logic of1;
    } flags_t;

    // strobes packed as {slow, fast, per}
    function automatic logic pick_tick(input logic [CR_SEL_W-1:0] code,
                                       input logic [2:0] strobes);
        logic hit;
        case (code)
            SRC_PER:  hit = strobes[0];
            SRC_FAST: hit = strobes[1];
            SRC_SLOW: hit = strobes[2];
            default:  hit = 1'b0;
        endcase
        return hit;
    endfunction

    function automatic logic [REG_W-1:0] status_word(input flags_t f);
        logic [REG_W-1:0] w;
        w = '0;
        w[SR_OF1] = f.of1;
        w[SR_ROV] = f.rov;
        return w;
    endfunction

endpackage

// File: rtl/cmp_timer_regs.sv
module cmp_timer_regs
    import cmp_timer_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PRE_W = 12,
    parameter int N_CMP = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       bus_we,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [REG_W-1:0]           bus_wdata,
    output logic [REG_W-1:0]           cr_q,
    output logic [PRE_W-1:0]           pr_q,
    output logic [MASK_W-1:0]          ir_q,
    output logic [N_CMP-1:0][CNT_W-1:0] ocr_q,
    output timer_ctl_t                 ctl
);

    logic wr_ctrl, wr_pre, wr_mask, wr_stat, wr_cmp1, swr;

    assign wr_ctrl = bus_we && (bus_addr == OFS_CTRL);
    assign wr_pre  = bus_we && (bus_addr == OFS_PRE);
    assign wr_mask = bus_we && (bus_addr == OFS_MASK);
    assign wr_stat = bus_we && (bus_addr == OFS_STAT);
    assign wr_cmp1 = bus_we && (bus_addr == OFS_CMP1);
    assign swr     = wr_ctrl && bus_wdata[CR_SWR];

    logic en_rise_restart;
    assign en_rise_restart = wr_ctrl && !swr && !cr_q[CR_EN]
                             && bus_wdata[CR_EN] && bus_wdata[CR_ENMOD];

    always_comb begin
        ctl.soft_rst = swr;
        ctl.cnt_zero = en_rise_restart || (wr_cmp1 && !cr_q[CR_FRR]);
        ctl.pre_clr  = wr_pre;
        ctl.flag_clr = wr_stat ? {bus_wdata[SR_ROV], bus_wdata[SR_OF1]} : 2'b00;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cr_q <= '0;
            pr_q <= '0;
            ir_q <= '0;
        end else begin
            if (wr_ctrl) begin
                cr_q <= bus_wdata & ~CR_RSVD_MASK & (swr ? ~CR_RUN_MASK : '1);
            end
            if (swr) begin
                pr_q <= '0;
                ir_q <= '0;
            end else begin
                if (wr_pre)  pr_q <= bus_wdata[PRE_W-1:0];
                if (wr_mask) ir_q <= bus_wdata[MASK_W-1:0];
            end
        end
    end

    for (genvar ch = 0; ch < N_CMP; ch++) begin : g_cmp
        logic             sel;
        logic [CNT_W-1:0] val;
        assign sel = bus_we && (bus_addr == ADDR_W'(int'(OFS_CMP1) + ch));
        always_ff @(posedge clk) begin
            if (rst || swr) begin
                val <= '1;
            end else if (sel) begin
                val <= bus_wdata[CNT_W-1:0];
            end
        end
        assign ocr_q[ch] = val;
    end

endmodule

// File: rtl/cmp_timer_tick.sv
module cmp_timer_tick
    import cmp_timer_pkg::*;
#(
    parameter int PRE_W = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                phase_clr,
    input  logic                en,
    input  logic [CR_SEL_W-1:0] src_sel,
    input  logic [2:0]          strobes,
    input  logic [PRE_W-1:0]    pr,
    output logic                adv
);

    logic [PRE_W-1:0] phase_q;
    logic             live;

    assign live = en && pick_tick(src_sel, strobes);
    assign adv  = live && (phase_q == pr);

    always_ff @(posedge clk) begin
        if (rst || phase_clr) begin
            phase_q <= '0;
        end else if (live) begin
            phase_q <= adv ? '0 : phase_q + 1'b1;
        end
    end

endmodule

// File: rtl/cmp_timer_count.sv
module cmp_timer_count
    import cmp_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  timer_ctl_t       ctl,
    input  logic             adv,
    input  logic             free_run,
    input  logic [CNT_W-1:0] ocr1,
    output logic [CNT_W-1:0] cnt_q,
    output flags_t           flags
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic at_cmp, at_max, step;
    logic [CNT_W-1:0] cnt_next;

    assign at_cmp = (cnt_q == ocr1);
    assign at_max = (cnt_q == CNT_MAX);
    assign step   = adv && !ctl.cnt_zero;

    always_comb begin
        if (ctl.cnt_zero) begin
            cnt_next = '0;
        end else if (adv) begin
            cnt_next = (!free_run && at_cmp) ? '0 : cnt_q + 1'b1;
        end else begin
            cnt_next = cnt_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || ctl.soft_rst) begin
            cnt_q <= '0;
            flags <= '0;
        end else begin
            cnt_q     <= cnt_next;
            flags.of1 <= (flags.of1 && !ctl.flag_clr[0]) || (step && at_cmp);
            flags.rov <= (flags.rov && !ctl.flag_clr[1]) || (step && at_max);
        end
    end

endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
    import cmp_timer_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PRE_W = 12
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [3:0]  bus_addr,
    input  logic        bus_we,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        tick_per,
    input  logic        tick_fast,
    input  logic        tick_slow,
    output logic        irq
);

    localparam int N_CMP = 3;

    logic [REG_W-1:0]            cr_q;
    logic [PRE_W-1:0]            pr_q;
    logic [MASK_W-1:0]           ir_q;
    logic [N_CMP-1:0][CNT_W-1:0] ocr_q;
    logic [CNT_W-1:0]            cnt_q;
    timer_ctl_t                  ctl;
    flags_t                      flags;
    logic                        adv;

    cmp_timer_regs #(.CNT_W(CNT_W), .PRE_W(PRE_W), .N_CMP(N_CMP)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cr_q      (cr_q),
        .pr_q      (pr_q),
        .ir_q      (ir_q),
        .ocr_q     (ocr_q),
        .ctl       (ctl)
    );

    cmp_timer_tick #(.PRE_W(PRE_W)) u_tick (
        .clk       (clk),
        .rst       (rst),
        .phase_clr (ctl.soft_rst || ctl.pre_clr),
        .en        (cr_q[CR_EN]),
        .src_sel   (cr_q[CR_SEL_LSB +: CR_SEL_W]),
        .strobes   ({tick_slow, tick_fast, tick_per}),
        .pr        (pr_q),
        .adv       (adv)
    );

    cmp_timer_count #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .adv      (adv),
        .free_run (cr_q[CR_FRR]),
        .ocr1     (ocr_q[0]),
        .cnt_q    (cnt_q),
        .flags    (flags)
    );

    always_comb begin
        case (bus_addr)
            OFS_CTRL:  bus_rdata = cr_q;
            OFS_PRE:   bus_rdata = REG_W'(pr_q);
            OFS_STAT:  bus_rdata = status_word(flags);
            OFS_MASK:  bus_rdata = REG_W'(ir_q);
            OFS_CMP1:  bus_rdata = REG_W'(ocr_q[0]);
            OFS_CMP2:  bus_rdata = REG_W'(ocr_q[1]);
            OFS_CMP3:  bus_rdata = REG_W'(ocr_q[2]);
            OFS_COUNT: bus_rdata = REG_W'(cnt_q);
            default:   bus_rdata = '0;
        endcase
    end

    assign irq = cr_q[CR_EN] && ((flags.of1 && ir_q[SR_OF1]) || (flags.rov && ir_q[SR_ROV]));

endmodule

// File: rtl/cmp_timer_checker.sv
module cmp_timer_checker
    import cmp_timer_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PRE_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_we,
    input logic [3:0]       bus_addr,
    input logic [31:0]      bus_wdata,
    input logic             irq,
    input logic [31:0]      cr_q,
    input logic [PRE_W-1:0] pr_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] ocr1_q,
    input logic             adv,
    input flags_t           flags
);

    logic [CNT_W-1:0] cnt_inc;
    assign cnt_inc = cnt_q + 1'b1;

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (!cr_q[CR_EN] && !bus_we) |=> $stable(cnt_q));  // R1

    AST_ADV_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        adv |-> cr_q[CR_EN]);  // R1

    AST_FREE_STEP: assert property (@(posedge clk) disable iff (rst)
        (adv && cr_q[CR_FRR] && !bus_we) |=> (cnt_q == $past(cnt_inc)));  // R2

    AST_RESTART_AT_CMP: assert property (@(posedge clk) disable iff (rst)
        (adv && !cr_q[CR_FRR] && (cnt_q == ocr1_q) && !bus_we) |=> (cnt_q == '0));  // R3

    AST_CMP_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        (adv && (cnt_q == ocr1_q) && !bus_we) |=> flags.of1);  // R4

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        irq |-> cr_q[CR_EN]);  // R8

    AST_SOFT_RESET: assert property (@(posedge clk) disable iff (rst)
        (bus_we && (bus_addr == OFS_CTRL) && bus_wdata[CR_SWR])
        |=> (cr_q[5:0] == '0 && cnt_q == '0 && pr_q == '0 && flags == '0));  // R10

endmodule

bind cmp_timer cmp_timer_checker #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .cr_q      (cr_q),
    .pr_q      (pr_q),
    .cnt_q     (cnt_q),
    .ocr1_q    (ocr_q[0]),
    .adv       (adv),
    .flags     (flags)
);

// File: tb/cmp_timer_bench.sv
module cmp_timer_bench;

    localparam int CW = 8;
    localparam logic [CW-1:0] CMAX = '1;
    localparam logic [31:0] EN = 32'h1, ENM = 32'h2, FR = 32'h200;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_per = 1'b0, tick_fast = 1'b0, tick_slow = 1'b0;
    logic        irq;

    always #5 clk = ~clk;

    cmp_timer #(.CNT_W(CW), .PRE_W(12)) u_cmp_timer (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_per(tick_per),
        .tick_fast(tick_fast), .tick_slow(tick_slow), .irq(irq)
    );

    // reference state
    logic [31:0]   m_cr;
    logic [11:0]   m_pr, m_ph;
    logic [5:0]    m_ir;
    logic          m_of, m_rov;
    logic [CW-1:0] m_cnt;
    logic [CW-1:0] m_cmp [3];

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    function automatic void model_reset();
        m_cr = '0; m_pr = '0; m_ph = '0; m_ir = '0;
        m_of = 0; m_rov = 0; m_cnt = '0;
        foreach (m_cmp[i]) m_cmp[i] = CMAX;
    endfunction

    function automatic logic [31:0] expect_read(input logic [3:0] a);
        case (a)
            4'd0: return m_cr;
            4'd1: return 32'(m_pr);
            4'd2: return {26'd0, m_rov, 4'd0, m_of};
            4'd3: return 32'(m_ir);
            4'd4: return 32'(m_cmp[0]);
            4'd5: return 32'(m_cmp[1]);
            4'd6: return 32'(m_cmp[2]);
            4'd9: return 32'(m_cnt);
            default: return 32'd0;
        endcase
    endfunction

    function automatic void model_step(input logic we, input logic [3:0] a,
                                       input logic [31:0] wd, input logic [2:0] tk);
        logic [2:0] sel;
        logic src, adv, swr, zero;
        sel = m_cr[8:6];
        src = (sel == 3'd1) ? tk[0] : (sel == 3'd2) ? tk[1] : (sel == 3'd4) ? tk[2] : 1'b0;
        adv = m_cr[0] && src && (m_ph == m_pr);
        swr = we && a == 4'd0 && wd[15];
        zero = (we && a == 4'd0 && !swr && !m_cr[0] && wd[0] && wd[1])
             || (we && a == 4'd4 && !m_cr[9]);
        if (m_cr[0] && src) m_ph = adv ? 12'd0 : m_ph + 12'd1;
        if (swr || (we && a == 4'd1)) m_ph = '0;
        if (we && a == 4'd2) begin
            if (wd[0]) m_of = 0;
            if (wd[5]) m_rov = 0;
        end
        if (zero) m_cnt = '0;
        else if (adv) begin
            if (m_cnt == m_cmp[0]) m_of = 1;
            if (m_cnt == CMAX) m_rov = 1;
            if (!m_cr[9] && m_cnt == m_cmp[0]) m_cnt = '0;
            else m_cnt = m_cnt + 1'b1;
        end
        if (we && a == 4'd0) m_cr = wd & ~32'h0000_FC00 & (swr ? ~32'h3F : 32'hFFFF_FFFF);
        if (swr) begin
            m_pr = '0; m_ir = '0; m_cnt = '0; m_of = 0; m_rov = 0;
            foreach (m_cmp[i]) m_cmp[i] = CMAX;
        end else if (we) begin
            case (a)
                4'd1: m_pr = wd[11:0];
                4'd3: m_ir = wd[5:0];
                4'd4: m_cmp[0] = wd[CW-1:0];
                4'd5: m_cmp[1] = wd[CW-1:0];
                4'd6: m_cmp[2] = wd[CW-1:0];
                default: ;
            endcase
        end
    endfunction

    task automatic cyc(input logic we, input logic [3:0] a, input logic [31:0] wd,
                       input logic [2:0] tk, input string tag);
        logic [31:0] er;
        logic ei;
        @(negedge clk);
        bus_we = we; bus_addr = a; bus_wdata = wd;
        {tick_slow, tick_fast, tick_per} = tk;
        #1;
        er = expect_read(a);
        ei = m_cr[0] && ((m_of && m_ir[0]) || (m_rov && m_ir[5]));
        vectors++;
        if (bus_rdata !== er || irq !== ei) begin
            errors++;
            $display("FAIL %s ofs=%0d rdata=%h irq=%b expected rdata=%h irq=%b",
                     tag, a, bus_rdata, irq, er, ei);
        end
        @(posedge clk);
        model_step(we, a, wd, tk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] wd, input string tag);
        cyc(1'b1, a, wd, 3'b000, tag);
    endtask

    task automatic rd(input logic [3:0] a, input string tag);
        cyc(1'b0, a, 32'd0, 3'b000, tag);
    endtask

    task automatic run(input int n, input logic [2:0] tk, input string tag);
        for (int i = 0; i < n; i++) cyc(1'b0, 4'd9, 32'd0, tk, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R12: reset values across the map
        for (int a = 0; a < 16; a++) rd(4'(a), "R12");

        // R5: source selection
        wr(0, EN | (32'd1 << 6) | FR, "R5");
        run(6, 3'b001, "R5");
        run(4, 3'b110, "R5");
        wr(0, EN | (32'd2 << 6) | FR, "R5");
        run(4, 3'b010, "R5");
        run(3, 3'b101, "R5");
        wr(0, EN | (32'd4 << 6) | FR, "R5");
        run(4, 3'b100, "R5");
        run(3, 3'b011, "R5");
        for (int c = 0; c < 8; c++) begin
            wr(0, EN | (32'(c) << 6) | FR, "R5");
            run(3, 3'b111, "R5");
        end

        // R6: prescaler division and phase restart
        wr(1, 32'hFFFF_F002, "R6");
        rd(1, "R6");
        wr(0, EN | (32'd1 << 6) | FR, "R6");
        run(9, 3'b001, "R6");
        for (int i = 0; i < 10; i++) cyc(1'b0, 4'd9, 32'd0, 3'(i % 2), "R6");
        run(1, 3'b001, "R6");
        wr(1, 32'd2, "R6");
        run(4, 3'b001, "R6");
        wr(1, 32'd0, "R6");
        run(3, 3'b001, "R6");

        // R1: hold while disabled
        wr(0, (32'd1 << 6) | FR, "R1");
        run(5, 3'b111, "R1");

        // R9: enable-mode restart versus resume
        wr(0, EN | ENM | (32'd1 << 6) | FR, "R9");
        run(5, 3'b001, "R9");
        wr(0, (32'd1 << 6) | FR, "R9");
        wr(0, EN | (32'd1 << 6) | FR, "R9");
        run(3, 3'b001, "R9");
        wr(0, EN | ENM | (32'd1 << 6) | FR, "R9");
        run(2, 3'b001, "R9");

        // R3: restart mode
        wr(0, (32'd1 << 6), "R3");
        run(2, 3'b001, "R3");
        wr(4, 32'd5, "R3");
        wr(0, EN | (32'd1 << 6), "R3");
        run(14, 3'b001, "R3");
        wr(4, 32'd3, "R3");
        run(10, 3'b001, "R3");

        // R7: write-one-to-clear and set-beats-clear
        wr(2, 32'd0, "R7");
        rd(2, "R7");
        wr(2, 32'h0000_0001, "R7");
        rd(2, "R7");
        for (int i = 0; i < 10; i++) cyc(1'b1, 4'd2, 32'h21, 3'b001, "R7");
        rd(2, "R7");

        // R2 and R4: free-run through compare and wrap
        wr(0, (32'd1 << 6) | FR, "R2");
        wr(2, 32'h21, "R2");
        wr(4, 32'd10, "R4");
        wr(3, 32'h21, "R4");
        wr(0, EN | ENM | (32'd1 << 6) | FR, "R2");
        run(270, 3'b001, "R2");
        rd(2, "R4");

        // R8: mask storage and interrupt gating
        wr(3, 32'hFFFF_FFFF, "R8");
        rd(3, "R8");
        wr(3, 32'h01, "R8");
        rd(2, "R8");
        wr(2, 32'h01, "R8");
        run(3, 3'b000, "R8");
        wr(3, 32'h20, "R8");
        run(2, 3'b000, "R8");
        wr(0, (32'd1 << 6) | FR, "R8");
        run(3, 3'b000, "R8");

        // R4: compare at all ones in free-run
        wr(2, 32'h21, "R4");
        wr(4, 32'hFF, "R4");
        wr(3, 32'h21, "R4");
        wr(0, EN | ENM | (32'd1 << 6) | FR, "R4");
        run(260, 3'b001, "R4");
        rd(2, "R4");

        // R11: ignored offsets, reserved bits, spare compares
        wr(9, 32'h55, "R11");
        wr(7, 32'h12, "R11");
        wr(8, 32'h34, "R11");
        rd(7, "R11");
        rd(8, "R11");
        wr(5, 32'hA5, "R11");
        wr(6, 32'h3C, "R11");
        rd(5, "R11");
        rd(6, "R11");
        wr(0, 32'hFFFF_7DFF, "R11");
        rd(0, "R11");
        for (int a = 10; a < 16; a++) rd(4'(a), "R11");
        run(4, 3'b111, "R11");

        // R10: soft reset
        wr(1, 32'd3, "R10");
        wr(3, 32'h21, "R10");
        wr(0, 32'hABCD_83FF, "R10");
        for (int a = 0; a < 10; a++) rd(4'(a), "R10");
        run(4, 3'b111, "R10");
        wr(0, 32'h0000_0041, "R10");
        run(4, 3'b001, "R10");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule